// File: doc/BRIEF.md
# Dual-Lane Halfword Multiply-Accumulate Unit

The unit treats each 64-bit operand as two 32-bit lanes. In every lane it takes one 16-bit halfword from operand A and the matching halfword from operand B, and it multiplies them. A set of control inputs picks which halfword is used, how the operands are read (signed or unsigned, integer or Q15 fractional), whether results wrap or clamp, and how the 64-bit accumulator is involved. The accumulator can be left alone, overwritten with the new result, or updated by adding each lane product into its own 32-bit half.

The unit has two pipeline stages. Operands and controls are sampled together with `in_valid`. The products are registered at the next edge. The edge after that registers the accumulate and saturate stage. `out_valid` marks a new result, two cycles after issue. Accumulation happens only in the second stage, so a new operation can be issued on every cycle and each one sees the accumulator written by the operation before it.

Each lane has two overflow bits. `ov_now` holds the overflow of the most recent saturating operation. `ov_sticky` collects every overflow until `sticky_clr` clears it.

Top module: `dual_hw_mac`

## Requirements
- R1: Lane 0 occupies bits 31:0 and lane 1 occupies bits 63:32 of every operand and result. With `sel_odd`=1 a lane uses the low halfword of its word (bits 15:0). With `sel_odd`=0 it uses the high halfword (bits 31:16).
- R2: Integer products are 16x16 to 32 bits: two's-complement when `is_signed`=1, unsigned otherwise. `result` and `out_valid` appear two clock edges after the `in_valid` edge, and operations may be issued back to back.
- R3: With `is_frac`=1 the operands are always signed and the product is the signed product shifted left by one bit. Without saturation, 0x8000 times 0x8000 gives 0x80000000 and raises no flag.
- R4: With `is_frac`=1 and `is_sat`=1, 0x8000 times 0x8000 gives 0x7FFFFFFF and sets the overflow bit of that lane. No other operand pair overflows.
- R5: `acc_mode` 2'b01 copies the 64-bit result into the accumulator. 2'b00 and 2'b11 leave the accumulator unchanged. The accumulator never changes in a cycle without `out_valid`.
- R6: `acc_mode` 2'b10 adds each lane product to the same lane's 32-bit accumulator half and writes the sum to both `result` and `acc_q`. Back-to-back operations chain through the accumulator without bubbles.
- R7: A signed saturating accumulate clamps a sum above the signed word range to 0x7FFFFFFF and a sum below it to 0x80000000, and sets the lane's overflow bit in either case.
- R8: An unsigned saturating accumulate clamps a sum above 0xFFFFFFFF to 0xFFFFFFFF and sets the lane's overflow bit.
- R9: With `is_sat`=0 each lane keeps the low 32 bits of its sum. The operation raises no overflow and leaves `ov_now` unchanged.
- R10: In a fractional saturating accumulate, the lane's overflow bit is the OR of the multiply clamp and the accumulate clamp.
- R11: Every saturating operation rewrites `ov_now`. `ov_sticky` ORs in each new overflow and is cleared by `sticky_clr`. When a clear and a new overflow reach the same edge, the new overflow is kept.
- R12: Synchronous active-high `rst` zeroes `out_valid`, `result`, `acc_q`, `ov_now` and `ov_sticky`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue an operation this cycle |
| op_a | input | 64 | Operand A, two 32-bit lanes |
| op_b | input | 64 | Operand B, two 32-bit lanes |
| sel_odd | input | 1 | 1: low halfword of each lane, 0: high halfword |
| is_signed | input | 1 | Signed operands (forced on when fractional) |
| is_frac | input | 1 | Q15 fractional multiply |
| is_sat | input | 1 | Saturating (1) or modulo (0) |
| acc_mode | input | 2 | 00/11 none, 01 load accumulator, 10 add into words |
| sticky_clr | input | 1 | Clear the sticky overflow bits at this edge |
| out_valid | output | 1 | Result registered this cycle |
| result | output | 64 | Two 32-bit lane results |
| acc_q | output | 64 | Accumulator |
| ov_now | output | 2 | Per-lane overflow of the last saturating operation |
| ov_sticky | output | 2 | Per-lane sticky overflow |

## Verification
Two events can reach the overflow state at the same edge: a clear of the sticky bits, and a saturating operation in its second stage that sets a lane flag. The bench provokes this by asserting `sticky_clr` in the issue cycle of the operation that follows an overflowing one. A reference model then predicts the sticky bits: the surviving value is the new overflow alone. A second case pairs a clear with a non-overflowing saturating operation and expects zero. Back-to-back accumulates also overlap a first-stage multiply with a second-stage accumulator update. These are judged by comparing every result and accumulator value against the model in issue order.

// File: rtl/dhm_pkg.sv
package dhm_pkg;

    typedef enum logic [1:0] {
        ACC_NONE = 2'b00,
        ACC_LOAD = 2'b01,
        ACC_ADD  = 2'b10
    } acc_mode_e;

    typedef struct packed {
        logic      sgn;
        logic      sat;
        acc_mode_e mode;
    } ctrl_t;

    function automatic acc_mode_e decode_mode(input logic [1:0] raw);
        case (raw)
            2'b01:   return ACC_LOAD;
            2'b10:   return ACC_ADD;
            default: return ACC_NONE;
        endcase
    endfunction

endpackage

// File: rtl/dhm_lane_mul.sv
module dhm_lane_mul #(
    parameter int HALF_W = 16
) (
    input  logic [2*HALF_W-1:0] a_word,
    input  logic [2*HALF_W-1:0] b_word,
    input  logic                sel_odd,
    input  logic                sgn,
    input  logic                frac,
    input  logic                sat,
    output logic [2*HALF_W-1:0] prod,
    output logic                mov
);
    localparam int WORD_W = 2 * HALF_W;
    localparam logic [HALF_W-1:0] MOST_NEG = {1'b1, {(HALF_W-1){1'b0}}};
    localparam logic [WORD_W-1:0] POS_MAX  = {1'b0, {(WORD_W-1){1'b1}}};

    logic [HALF_W-1:0]        ha, hb;
    logic signed [HALF_W:0]   xa, xb;
    logic signed [WORD_W+1:0] full;
    logic [WORD_W-1:0]        raw;

    always_comb begin
        ha   = sel_odd ? a_word[HALF_W-1:0] : a_word[WORD_W-1:HALF_W];
        hb   = sel_odd ? b_word[HALF_W-1:0] : b_word[WORD_W-1:HALF_W];
        xa   = {sgn & ha[HALF_W-1], ha};
        xb   = {sgn & hb[HALF_W-1], hb};
        full = xa * xb;
        raw  = frac ? {full[WORD_W-2:0], 1'b0} : full[WORD_W-1:0];
        mov  = frac & sat & (ha == MOST_NEG) & (hb == MOST_NEG);
        prod = mov ? POS_MAX : raw;
    end
endmodule

// File: rtl/dhm_lane_acc.sv
module dhm_lane_acc
    import dhm_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] prod,
    input  logic              mov,
    input  logic [WORD_W-1:0] acc_half,
    input  ctrl_t             ctrl,
    output logic [WORD_W-1:0] val,
    output logic              ov
);
    localparam logic [WORD_W-1:0] S_MAX = {1'b0, {(WORD_W-1){1'b1}}};
    localparam logic [WORD_W-1:0] S_MIN = {1'b1, {(WORD_W-1){1'b0}}};
    localparam logic [WORD_W-1:0] U_MAX = {WORD_W{1'b1}};

    logic [WORD_W+1:0] ea, ep, sum;
    logic              s_hi, s_lo, u_hi;

    always_comb begin
        ea   = ctrl.sgn ? {{2{acc_half[WORD_W-1]}}, acc_half} : {2'b00, acc_half};
        ep   = ctrl.sgn ? {{2{prod[WORD_W-1]}}, prod} : {2'b00, prod};
        sum  = ea + ep;
        s_hi = ~sum[WORD_W+1] & (sum[WORD_W] | sum[WORD_W-1]);
        s_lo = sum[WORD_W+1] & ~(sum[WORD_W] & sum[WORD_W-1]);
        u_hi = |sum[WORD_W+1:WORD_W];
        val  = prod;
        ov   = mov;
        if (ctrl.mode == ACC_ADD) begin
            val = sum[WORD_W-1:0];
            ov  = 1'b0;
            if (ctrl.sat) begin
                ov = mov;
                if (ctrl.sgn) begin
                    if (s_hi) begin val = S_MAX; ov = 1'b1; end
                    if (s_lo) begin val = S_MIN; ov = 1'b1; end
                end else if (u_hi) begin
                    val = U_MAX;
                    ov  = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dual_hw_mac.sv
module dual_hw_mac
    import dhm_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int LANES  = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [LANES*2*HALF_W-1:0]  op_a,
    input  logic [LANES*2*HALF_W-1:0]  op_b,
    input  logic                       sel_odd,
    input  logic                       is_signed,
    input  logic                       is_frac,
    input  logic                       is_sat,
    input  logic [1:0]                 acc_mode,
    input  logic                       sticky_clr,
    output logic                       out_valid,
    output logic [LANES*2*HALF_W-1:0]  result,
    output logic [LANES*2*HALF_W-1:0]  acc_q,
    output logic [LANES-1:0]           ov_now,
    output logic [LANES-1:0]           ov_sticky
);
    localparam int WORD_W = 2 * HALF_W;
    localparam int VEC_W  = LANES * WORD_W;

    ctrl_t              c_in, s1_ctrl;
    logic               s1_valid;
    logic [WORD_W-1:0]  m_prod [LANES];
    logic [LANES-1:0]   m_mov, s1_mov, a_ov, new_ov;
    logic [WORD_W-1:0]  s1_prod [LANES];
    logic [VEC_W-1:0]   next_vec;
    logic               stg2_valid, stg2_sat;

    always_comb begin
        c_in.sgn  = is_signed | is_frac;
        c_in.sat  = is_sat;
        c_in.mode = decode_mode(acc_mode);
    end

    for (genvar l = 0; l < LANES; l++) begin : g_mul
        dhm_lane_mul #(.HALF_W(HALF_W)) u_mul (
            .a_word (op_a[l*WORD_W +: WORD_W]),
            .b_word (op_b[l*WORD_W +: WORD_W]),
            .sel_odd(sel_odd),
            .sgn    (c_in.sgn),
            .frac   (is_frac),
            .sat    (is_sat),
            .prod   (m_prod[l]),
            .mov    (m_mov[l])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_ctrl  <= '0;
            s1_mov   <= '0;
            for (int i = 0; i < LANES; i++) s1_prod[i] <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_ctrl <= c_in;
                s1_mov  <= m_mov;
                for (int i = 0; i < LANES; i++) s1_prod[i] <= m_prod[i];
            end
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_acc
        logic [WORD_W-1:0] lane_val;
        dhm_lane_acc #(.WORD_W(WORD_W)) u_acc (
            .prod    (s1_prod[l]),
            .mov     (s1_mov[l]),
            .acc_half(acc_q[l*WORD_W +: WORD_W]),
            .ctrl    (s1_ctrl),
            .val     (lane_val),
            .ov      (a_ov[l])
        );
        assign next_vec[l*WORD_W +: WORD_W] = lane_val;
    end

    assign stg2_valid = s1_valid;
    assign stg2_sat   = s1_ctrl.sat;
    assign new_ov     = (stg2_valid && stg2_sat) ? a_ov : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            acc_q     <= '0;
            ov_now    <= '0;
            ov_sticky <= '0;
        end else begin
            out_valid <= stg2_valid;
            if (stg2_valid) begin
                result <= next_vec;
                if (s1_ctrl.mode != ACC_NONE) acc_q <= next_vec;
                if (stg2_sat) ov_now <= a_ov;
            end
            ov_sticky <= (ov_sticky & ~{LANES{sticky_clr}}) | new_ov;
        end
    end
endmodule

// File: rtl/dual_hw_mac_chk.sv
module dual_hw_mac_chk #(
    parameter int LANES = 2,
    parameter int VEC_W = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             out_valid,
    input logic [VEC_W-1:0] acc_q,
    input logic [LANES-1:0] ov_now,
    input logic [LANES-1:0] ov_sticky,
    input logic             sticky_clr,
    input logic             stg2_valid,
    input logic             stg2_sat
);
    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid);

    assert_acc_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(acc_q));

    assert_modulo_flags_R9: assert property (@(posedge clk) disable iff (rst)
        (stg2_valid && !stg2_sat) |=> $stable(ov_now));

    assert_sticky_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !sticky_clr |=> ((ov_sticky & $past(ov_sticky)) == $past(ov_sticky)));

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assert_sticky_follows_R11: assert property (@(posedge clk) disable iff (rst)
            $rose(ov_now[l]) |-> ov_sticky[l]);
    end
endmodule

bind dual_hw_mac dual_hw_mac_chk #(.LANES(LANES), .VEC_W(LANES*2*HALF_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .acc_q     (acc_q),
    .ov_now    (ov_now),
    .ov_sticky (ov_sticky),
    .sticky_clr(sticky_clr),
    .stg2_valid(stg2_valid),
    .stg2_sat  (stg2_sat)
);

// File: tb/dual_hw_mac_tb.sv
`timescale 1ns/1ps
module dual_hw_mac_tb;
    logic        clk = 0, rst = 1, in_valid = 0;
    logic [63:0] op_a = 0, op_b = 0;
    logic        sel_odd = 0, is_signed = 0, is_frac = 0, is_sat = 0, sticky_clr = 0;
    logic [1:0]  acc_mode = 0;
    logic        out_valid;
    logic [63:0] result, acc_q;
    logic [1:0]  ov_now, ov_sticky;

    always #2 clk = ~clk;

    dual_hw_mac u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .sel_odd(sel_odd), .is_signed(is_signed), .is_frac(is_frac), .is_sat(is_sat),
        .acc_mode(acc_mode), .sticky_clr(sticky_clr), .out_valid(out_valid),
        .result(result), .acc_q(acc_q), .ov_now(ov_now), .ov_sticky(ov_sticky)
    );

    typedef struct {
        logic [63:0] res;
        logic [63:0] acc;
        logic [1:0]  ovn;
        logic [1:0]  stk;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          total = 0, bad = 0;
    logic [63:0] m_acc = 0;
    logic [1:0]  m_ovn = 0, m_stk = 0;
    bit          pend_clr = 0;
    bit          done = 0;

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic void ref_lane(input logic [15:0] a, input logic [15:0] b,
                                     input bit sg, input bit fr, input bit st, input int md,
                                     input logic [31:0] acc,
                                     output logic [31:0] v, output bit ov);
        longint p, s;
        bit mv, se;
        mv = 0;
        se = sg | fr;
        p = se ? longint'($signed(a)) * longint'($signed(b)) : longint'(a) * longint'(b);
        if (fr) p = p * 2;
        if (fr && st && p == 64'sd2147483648) begin p = 64'sd2147483647; mv = 1; end
        ov = mv;
        if (md != 2) begin
            v = p[31:0];
        end else begin
            s = (se ? longint'($signed(acc)) : longint'(acc)) + p;
            v = s[31:0];
            if (!st) ov = 0;
            else if (se) begin
                if (s > 64'sd2147483647)  begin v = 32'h7FFF_FFFF; ov = 1; end
                if (s < -64'sd2147483648) begin v = 32'h8000_0000; ov = 1; end
            end else if (s > 64'sd4294967295) begin
                v = 32'hFFFF_FFFF; ov = 1;
            end
        end
    endfunction

    task automatic issue(input logic [63:0] a, input logic [63:0] b, input bit odd,
                         input bit sg, input bit fr, input bit st, input int md,
                         input bit clr_along, input string tag);
        exp_t e;
        logic [31:0] v;
        bit ov;
        logic [1:0] ovv;
        @(negedge clk);
        for (int l = 0; l < 2; l++) begin
            ref_lane(odd ? a[l*32 +: 16] : a[l*32+16 +: 16],
                     odd ? b[l*32 +: 16] : b[l*32+16 +: 16],
                     sg, fr, st, md, m_acc[l*32 +: 32], v, ov);
            e.res[l*32 +: 32] = v;
            ovv[l] = ov;
        end
        if (md == 1 || md == 2) m_acc = e.res;
        if (st) m_ovn = ovv;
        m_stk = (clr_along ? 2'b00 : m_stk) | (st ? ovv : 2'b00);
        e.acc = m_acc; e.ovn = m_ovn; e.stk = m_stk; e.tag = tag;
        sb.push_back(e);
        in_valid = 1; op_a = a; op_b = b; sel_odd = odd; is_signed = sg;
        is_frac = fr; is_sat = st; acc_mode = md[1:0];
        sticky_clr = pend_clr; pend_clr = clr_along;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 0; sticky_clr = pend_clr; pend_clr = 0;
        end
    endtask

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb.size() == 0) begin
                total++; bad++;
                $display("FAIL R2 unexpected out_valid got=1 exp=0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " result"}, result, e.res);
                check({e.tag, " acc"}, acc_q, e.acc);
                check({e.tag, " ov_now"}, {62'b0, ov_now}, {62'b0, e.ovn});
                check({e.tag, " ov_sticky"}, {62'b0, ov_sticky}, {62'b0, e.stk});
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog got=timeout exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R12: reset state
        check("R12 out_valid", {63'b0, out_valid}, 64'd0);
        check("R12 result", result, 64'd0);
        check("R12 acc", acc_q, 64'd0);
        check("R12 flags", {60'b0, ov_now, ov_sticky}, 64'd0);

        // R1 / R2: halfword selection, signed and unsigned integer
        issue(64'h8000_0001_7FFF_0002, 64'h0003_FFFF_FFFF_F000, 0, 1, 0, 0, 0, 0, "R1 even signed");
        issue(64'h8000_0001_7FFF_0002, 64'h0003_FFFF_FFFF_F000, 1, 0, 0, 0, 0, 0, "R2 odd unsigned");
        issue(64'h8000_0001_7FFF_0002, 64'h0003_FFFF_FFFF_F000, 1, 1, 0, 0, 0, 0, "R1 odd signed");
        issue(64'hFFFF_1234_FFFF_8001, 64'hFFFF_0002_FFFF_8001, 0, 0, 0, 0, 0, 0, "R2 even unsigned");
        // R3 / R4: fractional modulo and saturating
        issue(64'h0000_8000_0000_4000, 64'h0000_8000_0000_C000, 1, 0, 1, 0, 0, 0, "R3 frac modulo");
        issue(64'h0000_8000_0000_4000, 64'h0000_8000_0000_C000, 1, 0, 1, 1, 0, 0, "R4 frac sat");
        issue(64'h8000_0000_7FFF_0000, 64'h7FFF_0000_8000_0000, 0, 0, 1, 1, 0, 0, "R4 near extremes");
        idle(3);
        // R5: load then no-accumulate and mode 11
        issue(64'h0010_0000_FFF0_0000, 64'h0010_0000_0003_0000, 0, 1, 0, 0, 1, 0, "R5 load");
        issue(64'h0000_0555_0000_0777, 64'h0000_0002_0000_0003, 1, 1, 0, 0, 0, 0, "R5 none");
        issue(64'h0000_0555_0000_0777, 64'h0000_0002_0000_0003, 1, 1, 0, 0, 3, 0, "R5 mode11");
        // R6: back-to-back add into words (signed modulo)
        issue(64'h0000_0100_0000_FF00, 64'h0000_0100_0000_0100, 1, 1, 0, 0, 2, 0, "R6 add1");
        issue(64'h0000_0100_0000_FF00, 64'h0000_0100_0000_0100, 1, 1, 0, 0, 2, 0, "R6 add2");
        issue(64'h0000_7FFF_0000_1234, 64'h0000_7FFF_0000_4321, 1, 1, 0, 0, 2, 0, "R6 add3");
        // R7: signed saturating accumulate, both directions
        issue(64'h0, 64'h0, 1, 1, 0, 0, 1, 0, "R7 clear acc");
        for (int i = 0; i < 3; i++)
            issue(64'h0000_8000_0000_7FFF, 64'h0000_7FFF_0000_7FFF, 1, 1, 0, 1, 2, 0, "R7 sat add");
        // R8: unsigned saturating accumulate
        issue(64'h0, 64'h0, 1, 0, 0, 0, 1, 0, "R8 clear acc");
        for (int i = 0; i < 2; i++)
            issue(64'h0000_FFFF_0000_FFFF, 64'h0000_FFFF_0000_0001, 1, 0, 0, 1, 2, 0, "R8 usat add");
        // R9: modulo wrap keeps ov_now
        issue(64'h0000_FFFF_0000_FFFF, 64'h0000_FFFF_0000_FFFF, 1, 0, 0, 0, 2, 0, "R9 wrap");
        // R10: fractional saturating accumulate
        issue(64'h0, 64'h0, 1, 1, 0, 0, 1, 0, "R10 clear acc");
        issue(64'h8000_0000_8000_0000, 64'h8000_0000_4000_0000, 0, 0, 1, 1, 2, 0, "R10 mul clamp");
        issue(64'h8000_0000_8000_0000, 64'h8000_0000_4000_0000, 0, 0, 1, 1, 2, 0, "R10 acc clamp");
        idle(4);
        // R11: standalone clear
        @(negedge clk); sticky_clr = 1; m_stk = 0;
        @(negedge clk); sticky_clr = 0;
        check("R11 cleared", {62'b0, ov_sticky}, 64'd0);
        // R11: clear together with a new overflow, then with no overflow
        issue(64'h0000_8000_0000_0001, 64'h0000_8000_0000_0001, 1, 0, 1, 1, 0, 1, "R11 set beats clear");
        issue(64'h0000_0001_0000_0001, 64'h0000_0001_0000_0001, 1, 0, 1, 1, 0, 1, "R11 clear only");
        issue(64'h0000_0001_0000_0001, 64'h0000_0001_0000_0001, 1, 1, 0, 0, 0, 0, "R11 after");
        idle(6);
        check("R2 queue drained", {32'b0, sb.size()}, 64'd0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule